// File: doc/BRIEF.md
# Sinc3 Fast Over/Under Limit Detector

This block watches a one-bit sigma-delta modulator stream and finds out-of-range conditions, such as an overcurrent on a shunt, within a few microseconds. A precision decimator on the same stream is slower, so this block runs its own coarse third-order sinc filter at a decimation ratio of 32. The modulator clock and data are brought into the system clock domain. A bit is taken on each rising edge of the modulator clock, and the filter produces one unsigned result per 32 bits.

Each result is clamped to the largest positive 16-bit value. It is then compared with two 16-bit limits. A result above the upper limit latches an over flag, and a result below the lower limit latches an under flag. Each flag stays set until its own clear input is pulsed. Each flag also has its own enable, and the single interrupt output is the OR of the enabled flags. After reset, the first three filter results are not compared, because the filter history is not yet full.

Top module: `sdcmp_top`

## Requirements
- R1: One modulator bit is taken for each rising edge of `mod_clk`, using the value of `mod_data` at that edge. The modulator changes its data on the falling edge.
- R2: `filt_out` is the unsigned sinc3 result at a decimation ratio of 32. In steady state, for a periodic bit pattern that has k ones in every 8 bits, it equals k*4096. All zeros give 0.
- R3: A result above 0x7FFF is clamped, so an all-ones stream reads 0x7FFF and not 32768.
- R4: `filt_stb` pulses for one cycle after every 32 modulator bits, and `filt_out` is valid while it is high.
- R5: `over_flag` sets one cycle after a result strictly greater than `hi_lim`. A result equal to the limit does not set it.
- R6: `under_flag` sets one cycle after a result strictly less than `lo_lim`. A result equal to the limit does not set it.
- R7: The first three results after reset are never compared, so no flag can be set by them.
- R8: The flags are sticky. A flag stays set when later results are in range, and a one-cycle pulse on `clr_over` or `clr_under` returns that flag to 0. If a comparison sets a flag in the same cycle as its clear, the set wins.
- R9: `irq` equals (`over_flag` AND `en_over`) OR (`under_flag` AND `en_under`). The enables mask only `irq` and never the flags.
- R10: After reset, `filt_out`, `filt_stb`, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_clk | input | 1 | Modulator bit clock (asynchronous, slower than clk) |
| mod_data | input | 1 | Modulator bit stream |
| hi_lim | input | 16 | Upper limit, unsigned |
| lo_lim | input | 16 | Lower limit, unsigned |
| en_over | input | 1 | Passes the over flag to irq |
| en_under | input | 1 | Passes the under flag to irq |
| clr_over | input | 1 | Clears the over flag |
| clr_under | input | 1 | Clears the under flag |
| filt_out | output | 16 | Clamped filter result |
| filt_stb | output | 1 | Result valid strobe |
| over_flag | output | 1 | Sticky over-limit flag |
| under_flag | output | 1 | Sticky under-limit flag |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The bench sets both limits exactly equal to a steady filter result. A design that compared with greater-or-equal would then raise a flag the requirements forbid. An all-ones stream is run against an upper limit of 0x7FFE and against one of 0x7FFF. This shows whether the clamp is present: without it the value 32768 would trip a limit of 0x7FFF. Starting from reset with an all-ones stream and an upper limit of zero, the bench counts the result strobes. A design without the settling delay would latch a flag before the fourth result. The bench also checks that a cleared flag stays low, that a masked flag still latches, and that strobes are spaced 32 bits apart, which catches a decimation counter that is off by one.

// File: rtl/sdcmp_pkg.sv
package sdcmp_pkg;

    // The pair of sticky limit flags.
    typedef struct packed {
        logic over;
        logic under;
    } lim_flags_t;

endpackage

// File: rtl/sdcmp_capture.sv
// Brings the modulator clock and data into the system domain.
// Emits one strobe per modulator rising edge, with the data seen at that edge.
module sdcmp_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_clk,
    input  logic mod_data,
    output logic bit_stb,
    output logic bit_val
);

    typedef struct packed {
        logic [2:0] ck;
        logic [1:0] dt;
        logic       stb;
        logic       bv;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.ck  = {cap_q.ck[1:0], mod_clk};
        cap_d.dt  = {cap_q.dt[0], mod_data};
        // Taps ck[1] and dt[1] have the same age.
        cap_d.stb = cap_q.ck[1] & ~cap_q.ck[2];
        cap_d.bv  = cap_q.dt[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign bit_stb = cap_q.stb;
    assign bit_val = cap_q.bv;

    // An edge needs a low sample before it, so two strobes never touch.
    AST_BIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb); // R1

endmodule

// File: rtl/sdcmp_sinc3.sv
// Third-order sinc decimator with wrap-around accumulators.
// The output is clamped to the largest positive OUT_W-bit value.
module sdcmp_sinc3 #(
    parameter int OSR   = 32,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             bit_val,
    output logic             dec_stb,
    output logic [OUT_W-1:0] dec_val
);

    localparam int ACC_W = 3 * $clog2(OSR) + 1;
    localparam int CNT_W = $clog2(OSR);
    localparam int EXT_W = (ACC_W > OUT_W) ? ACC_W : OUT_W;
    localparam logic [EXT_W-1:0] SAT_X = EXT_W'((64'd1 << (OUT_W - 1)) - 64'd1);
    localparam logic [OUT_W-1:0] SAT_V = SAT_X[OUT_W-1:0];

    typedef struct packed {
        logic [ACC_W-1:0] i1;
        logic [ACC_W-1:0] i2;
        logic [ACC_W-1:0] i3;
        logic [ACC_W-1:0] d1;
        logic [ACC_W-1:0] d2;
        logic [ACC_W-1:0] d3;
        logic [CNT_W-1:0] cnt;
        logic             stb;
        logic [OUT_W-1:0] val;
    } sinc_t;

    sinc_t sinc_d, sinc_q;
    logic [ACC_W-1:0] c1, c2, c3;
    logic [EXT_W-1:0] c3x;

    always_comb begin
        sinc_d     = sinc_q;
        sinc_d.stb = 1'b0;
        c1  = '0;
        c2  = '0;
        c3  = '0;
        c3x = '0;
        if (bit_stb) begin
            sinc_d.i1 = sinc_q.i1 + ACC_W'(bit_val);
            sinc_d.i2 = sinc_q.i2 + sinc_q.i1;
            sinc_d.i3 = sinc_q.i3 + sinc_q.i2;
            if (sinc_q.cnt == CNT_W'(OSR - 1)) begin
                sinc_d.cnt = '0;
                c1 = sinc_d.i3 - sinc_q.d1;
                c2 = c1 - sinc_q.d2;
                c3 = c2 - sinc_q.d3;
                sinc_d.d1  = sinc_d.i3;
                sinc_d.d2  = c1;
                sinc_d.d3  = c2;
                c3x        = EXT_W'(c3);
                sinc_d.val = (c3x > SAT_X) ? SAT_V : c3x[OUT_W-1:0];
                sinc_d.stb = 1'b1;
            end else begin
                sinc_d.cnt = sinc_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sinc_q <= '0;
        else        sinc_q <= sinc_d;
    end

    assign dec_stb = sinc_q.stb;
    assign dec_val = sinc_q.val;

    AST_DEC_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stb |-> (dec_val <= SAT_V)); // R3
    AST_DEC_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stb |-> $past(bit_stb)); // R4

endmodule

// File: rtl/sdcmp_limits.sv
// Compares each decimated result with the two limits and latches sticky flags.
// Results are ignored until SETTLE strobes have passed since reset.
module sdcmp_limits
    import sdcmp_pkg::*;
#(
    parameter int THR_W  = 16,
    parameter int SETTLE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_stb,
    input  logic [THR_W-1:0] dec_val,
    input  logic [THR_W-1:0] hi_lim,
    input  logic [THR_W-1:0] lo_lim,
    input  logic             clr_over,
    input  logic             clr_under,
    output lim_flags_t       flags
);

    localparam int SET_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

    typedef struct packed {
        lim_flags_t       fl;
        logic [SET_W-1:0] seen;
    } lim_t;

    lim_t lim_d, lim_q;
    logic armed, cmp_en;

    always_comb begin
        lim_d  = lim_q;
        armed  = (lim_q.seen == SET_W'(SETTLE));
        cmp_en = dec_stb & armed;
        if (dec_stb && !armed) lim_d.seen = lim_q.seen + 1'b1;
        if (clr_over)  lim_d.fl.over  = 1'b0;
        if (clr_under) lim_d.fl.under = 1'b0;
        // A set in the same cycle as a clear wins.
        if (cmp_en && (dec_val > hi_lim)) lim_d.fl.over  = 1'b1;
        if (cmp_en && (dec_val < lo_lim)) lim_d.fl.under = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lim_q <= '0;
        else        lim_q <= lim_d;
    end

    assign flags = lim_q.fl;

    AST_OVER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.over) |-> $past(dec_stb && (dec_val > hi_lim))); // R5
    AST_UNDER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.under) |-> $past(dec_stb && (dec_val < lo_lim))); // R6
    AST_OVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.over && !clr_over) |=> flags.over); // R8
    AST_CLR_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_over && !dec_stb) |=> !flags.over); // R8
    AST_CLR_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_under && !dec_stb) |=> !flags.under); // R8

endmodule

// File: rtl/sdcmp_top.sv
module sdcmp_top
    import sdcmp_pkg::*;
#(
    parameter int OSR    = 32,
    parameter int THR_W  = 16,
    parameter int SETTLE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_clk,
    input  logic             mod_data,
    input  logic [THR_W-1:0] hi_lim,
    input  logic [THR_W-1:0] lo_lim,
    input  logic             en_over,
    input  logic             en_under,
    input  logic             clr_over,
    input  logic             clr_under,
    output logic [THR_W-1:0] filt_out,
    output logic             filt_stb,
    output logic             over_flag,
    output logic             under_flag,
    output logic             irq
);

    logic       bit_stb, bit_val;
    lim_flags_t flags;

    sdcmp_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_clk  (mod_clk),
        .mod_data (mod_data),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val)
    );

    sdcmp_sinc3 #(.OSR(OSR), .OUT_W(THR_W)) u_sinc (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .dec_stb (filt_stb),
        .dec_val (filt_out)
    );

    sdcmp_limits #(.THR_W(THR_W), .SETTLE(SETTLE)) u_lim (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_stb   (filt_stb),
        .dec_val   (filt_out),
        .hi_lim    (hi_lim),
        .lo_lim    (lo_lim),
        .clr_over  (clr_over),
        .clr_under (clr_under),
        .flags     (flags)
    );

    assign over_flag  = flags.over;
    assign under_flag = flags.under;
    assign irq        = (flags.over & en_over) | (flags.under & en_under);

endmodule

// File: tb/sim_sdcmp_top.sv
module sim_sdcmp_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_clk, mod_data;
    logic [15:0] hi_lim, lo_lim;
    logic        en_over, en_under, clr_over, clr_under;
    logic [15:0] filt_out;
    logic        filt_stb, over_flag, under_flag, irq;

    logic [7:0]  pat = 8'hFF;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    sdcmp_top u0 (
        .clk(clk), .rst_n(rst_n), .mod_clk(mod_clk), .mod_data(mod_data),
        .hi_lim(hi_lim), .lo_lim(lo_lim), .en_over(en_over), .en_under(en_under),
        .clr_over(clr_over), .clr_under(clr_under), .filt_out(filt_out),
        .filt_stb(filt_stb), .over_flag(over_flag), .under_flag(under_flag), .irq(irq)
    );

    // Modulator model: 4 system clocks per bit, new data on the falling edge.
    initial begin
        logic [1:0] ph;
        logic [2:0] bi;
        ph = 2'd0;
        bi = 3'd0;
        mod_clk  = 1'b0;
        mod_data = 1'b0;
        forever begin
            @(negedge clk);
            ph = ph + 2'd1;
            mod_clk = ph[1];
            if (ph == 2'd0) begin
                mod_data = pat[bi];
                bi = bi + 3'd1;
            end
        end
    end

    typedef struct packed {
        logic [7:0]  p;
        logic [15:0] hi;
        logic [15:0] lo;
        logic [15:0] val;
        logic        ov;
        logic        un;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{8'hFF, 16'h7FFE, 16'h0000, 16'h7FFF, 1'b1, 1'b0},  // R3 clamp trips just below
        '{8'hFF, 16'h7FFF, 16'h0000, 16'h7FFF, 1'b0, 1'b0},  // R3 clamp keeps max quiet
        '{8'h55, 16'h3FFF, 16'h0000, 16'h4000, 1'b1, 1'b0},  // R5
        '{8'h55, 16'h4000, 16'h4000, 16'h4000, 1'b0, 1'b0},  // R5 R6 equality
        '{8'h55, 16'hFFFF, 16'h4001, 16'h4000, 1'b0, 1'b1},  // R6
        '{8'h01, 16'h1000, 16'h1001, 16'h1000, 1'b0, 1'b1},  // R6
        '{8'h3F, 16'h5FFF, 16'h6000, 16'h6000, 1'b1, 1'b0},  // R5
        '{8'h00, 16'hFFFF, 16'h0001, 16'h0000, 1'b0, 1'b1},  // R6
        '{8'h77, 16'h0000, 16'h0000, 16'h6000, 1'b1, 1'b0},  // R5
        '{8'h0F, 16'h4000, 16'h4000, 16'h4000, 1'b0, 1'b0}   // R5 R6 equality
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_stb(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!filt_stb) @(negedge clk);
        end
    endtask

    task automatic pulse_clr();
        clr_over  = 1'b1;
        clr_under = 1'b1;
        @(negedge clk);
        clr_over  = 1'b0;
        clr_under = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int t0;
        hi_lim = 16'h0000; lo_lim = 16'h0000;
        en_over = 1'b1; en_under = 1'b1;
        clr_over = 1'b0; clr_under = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 filt_out", filt_out, 0);
        chk("R10 filt_stb", filt_stb, 0);
        chk("R10 flags", {over_flag, under_flag, irq}, 0);

        // R7 first three results ignored even though all-ones exceeds hi=0
        wait_stb(3);
        repeat (2) @(negedge clk);
        chk("R7 over after 3 results", over_flag, 0);
        chk("R7 irq after 3 results", irq, 0);
        wait_stb(1);
        repeat (2) @(negedge clk);
        chk("R7 over after 4th result", over_flag, 1);

        // R4 strobe spacing: 32 bits * 4 clocks
        wait_stb(1);
        t0 = 0;
        @(negedge clk);
        while (!filt_stb) begin
            t0++;
            @(negedge clk);
        end
        chk("R4 strobe spacing", t0 + 1, 128);

        // Vector table: R1 R2 R3 R5 R6 R9
        for (int r = 0; r < 10; r++) begin
            hi_lim = 16'hFFFF;
            lo_lim = 16'h0000;
            pulse_clr();
            pat = VEC[r].p;
            wait_stb(5);
            chk("R1 R2 filt_out", filt_out, VEC[r].val);
            hi_lim = VEC[r].hi;
            lo_lim = VEC[r].lo;
            wait_stb(1);
            repeat (2) @(negedge clk);
            chk("R5 over_flag", over_flag, VEC[r].ov);
            chk("R6 under_flag", under_flag, VEC[r].un);
            chk("R9 irq", irq, VEC[r].ov | VEC[r].un);
        end

        // R8 sticky, then clear
        hi_lim = 16'hFFFF; lo_lim = 16'h0000;
        pulse_clr();
        pat = 8'hFF;
        hi_lim = 16'h0000;
        wait_stb(1);
        repeat (2) @(negedge clk);
        chk("R8 over set", over_flag, 1);
        hi_lim = 16'hFFFF;
        wait_stb(2);
        repeat (2) @(negedge clk);
        chk("R8 over stays set", over_flag, 1);
        clr_over = 1'b1;
        @(negedge clk);
        clr_over = 1'b0;
        @(negedge clk);
        chk("R8 over cleared", over_flag, 0);
        wait_stb(1);
        repeat (2) @(negedge clk);
        chk("R8 over stays clear", over_flag, 0);

        // R9 masking affects irq only
        en_over = 1'b0;
        hi_lim = 16'h0000;
        wait_stb(1);
        repeat (2) @(negedge clk);
        chk("R9 masked flag still latches", over_flag, 1);
        chk("R9 masked irq", irq, 0);
        en_over = 1'b1;
        @(negedge clk);
        chk("R9 unmasked irq", irq, 1);
        en_over = 1'b0;
        en_under = 1'b1;
        @(negedge clk);
        chk("R9 under enable without under flag", irq, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule